// File: doc/BRIEF.md
# Eight-Channel Low-Side Output Fault Protection

This block sits between the output command latch of an eight-channel low-side switch and the gate drivers. Each channel receives its commanded on/off state. It also receives three digital fault indications: overcurrent, overtemperature and open load. From these it decides whether the gate is actually driven, and it produces a drain-level status bit that the serial status capture samples. The comparators and the analog current limiter sit outside the block and are seen only as flags. Each flag passes through a two-flop synchronizer before the block uses it.

A global mode input sets how overcurrent is handled. When the mode input is low, an overcurrent turns the channel off at once and holds it off until the next write cycle. A write cycle is marked by a one-cycle strobe derived from the chip-select rising edge. When the mode input is high, the channel stays on in current-limit mode. Overtemperature shuts a channel down in either mode, and the channel recovers by itself once the flag clears. Every fault acts only on the channel where it occurs.

The status bit reports the level of the drain. A healthy channel that is off reads high, and a healthy channel that is on reads low. A channel with a fault reads the opposite of its healthy level.

Top module: `fp_protect`

## Requirements
- R1: A channel's gate enable is never high while that channel's command is off.
- R2: A synchronous reset or the undervoltage input clears every overcurrent latch. The next cycle, each channel's gate follows its command again.
- R3: With the mode input low, an overcurrent flag on a commanded-on channel drives its gate enable low two clock edges after the flag is applied. An overcurrent flag on a commanded-off channel sets no latch.
- R4: An overcurrent latch-off persists after the flag clears. It releases only on the next write strobe, after which the gate follows the command.
- R5: With the mode input high, an overcurrent keeps the gate enabled and drives the channel's status bit to 1.
- R6: A fault on one channel changes no other channel's gate enable or status bit.
- R7: An overtemperature flag disables the channel's gate in either mode. The gate returns without a write strobe once the flag clears, provided the command is still on.
- R8: Open load drives the status bit to 0 only when the channel is commanded off. A commanded-on channel ignores the open-load flag.
- R9: Status bit encoding: 1 means the drain is high and 0 means the drain is low. Off with no fault gives 1. On with no fault gives 0. On but shut down by a fault gives 1.
- R10: Each fault flag passes through two synchronizing flops. A flag applied before an edge has no effect on the outputs after that first edge, and takes effect after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_i | input | 1 | Undervoltage indication, clears latches |
| limit_mode_i | input | 1 | 0 = latched shutdown on overcurrent, 1 = sustained current limit |
| write_strobe_i | input | 1 | One-cycle pulse at the end of each serial write |
| cmd_on_i | input | NUM_CH | Commanded state per channel, 1 = on |
| oc_i | input | NUM_CH | Overcurrent flag per channel |
| ot_i | input | NUM_CH | Overtemperature flag per channel |
| ol_i | input | NUM_CH | Open-load flag per channel |
| gate_en_o | output | NUM_CH | Final gate enable per channel |
| drain_stat_o | output | NUM_CH | Drain-level status per channel |

## Verification
A table of vectors drives mixed command patterns such as A5, 0F and FF. Each pattern places faults on chosen channels, so that faulted channels and untouched neighbours are checked side by side.

Overcurrent is applied in both modes:
- In latched mode, a vector drops the flag without a strobe and a later vector adds the strobe. This separates a true latch from plain gating.
- In limit mode, overcurrent is combined with overtemperature. This shows that thermal shutdown still wins while current limiting does not turn the channel off.

Open load is placed on one commanded-on channel and one commanded-off channel, which shows the flag counts only when the channel is off. Directed steps sample one edge and two edges after a flag changes, which separates a two-flop delay from a one-flop delay. Pulses on reset and on the undervoltage input confirm that each one releases a latch.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef struct packed {
        logic oc;
        logic ot;
        logic ol;
    } fp_flags_t;

    typedef enum logic {
        FP_RUN     = 1'b0,
        FP_LATCHED = 1'b1
    } fp_latch_e;

    localparam int FP_SYNC_STAGES = 2;

    function automatic fp_latch_e fp_latch_next(
        input fp_latch_e cur,
        input logic      clr,
        input logic      strobe,
        input logic      cmd,
        input logic      limit_mode,
        input logic      oc
    );
        fp_latch_e nxt;
        nxt = cur;
        if (clr || strobe) begin
            nxt = FP_RUN;
        end else if (!limit_mode && cmd && oc) begin
            nxt = FP_LATCHED;
        end
        return nxt;
    endfunction

    function automatic logic fp_gate_allow(
        input logic      cmd,
        input fp_latch_e st,
        input logic      limit_mode,
        input fp_flags_t f
    );
        return cmd && (st == FP_RUN) && !f.ot && (limit_mode || !f.oc);
    endfunction

    function automatic logic fp_drain_level(
        input logic      cmd,
        input logic      gate,
        input fp_flags_t f
    );
        return cmd ? (!gate || f.oc) : !f.ol;
    endfunction

endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe[s] <= '0;
            end
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/fp_channel.sv
module fp_channel
    import fp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_i,
    input  logic      limit_mode_i,
    input  logic      strobe_i,
    input  logic      cmd_i,
    input  fp_flags_t flags_i,
    output logic      gate_o,
    output logic      drain_o
);
    fp_latch_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FP_RUN;
        end else begin
            state_q <= fp_latch_next(state_q, clr_i, strobe_i, cmd_i,
                                     limit_mode_i, flags_i.oc);
        end
    end

    always_comb begin
        gate_o  = fp_gate_allow(cmd_i, state_q, limit_mode_i, flags_i);
        drain_o = fp_drain_level(cmd_i, gate_o, flags_i);
    end
endmodule

// File: rtl/fp_protect.sv
module fp_protect
    import fp_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_i,
    input  logic              limit_mode_i,
    input  logic              write_strobe_i,
    input  logic [NUM_CH-1:0] cmd_on_i,
    input  logic [NUM_CH-1:0] oc_i,
    input  logic [NUM_CH-1:0] ot_i,
    input  logic [NUM_CH-1:0] ol_i,
    output logic [NUM_CH-1:0] gate_en_o,
    output logic [NUM_CH-1:0] drain_stat_o
);
    localparam int FLAG_W = 3 * NUM_CH;

    logic [FLAG_W-1:0] raw_flags;
    logic [FLAG_W-1:0] sync_flags;

    assign raw_flags = {ol_i, ot_i, oc_i};

    fp_sync #(
        .W      (FLAG_W),
        .STAGES (FP_SYNC_STAGES)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (sync_flags)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fp_flags_t ch_flags;

        always_comb begin
            ch_flags.oc = sync_flags[c];
            ch_flags.ot = sync_flags[NUM_CH + c];
            ch_flags.ol = sync_flags[2*NUM_CH + c];
        end

        fp_channel i_ch (
            .clk          (clk),
            .rst          (rst),
            .clr_i        (uv_i),
            .limit_mode_i (limit_mode_i),
            .strobe_i     (write_strobe_i),
            .cmd_i        (cmd_on_i[c]),
            .flags_i      (ch_flags),
            .gate_o       (gate_en_o[c]),
            .drain_o      (drain_stat_o[c])
        );
    end
endmodule

// File: rtl/fp_protect_chk.sv
module fp_protect_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              uv_i,
    input logic              limit_mode_i,
    input logic              write_strobe_i,
    input logic [NUM_CH-1:0] cmd_on_i,
    input logic [NUM_CH-1:0] oc_i,
    input logic [NUM_CH-1:0] ot_i,
    input logic [NUM_CH-1:0] ol_i,
    input logic [NUM_CH-1:0] gate_en_o,
    input logic [NUM_CH-1:0] drain_stat_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
            gate_en_o[i] |-> cmd_on_i[i]); // R1

        AST_OC_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && !limit_mode_i && $past(oc_i[i], 2))
            |-> !gate_en_o[i]); // R3

        AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$past(uv_i)
             && !$past(write_strobe_i) && !limit_mode_i && !$past(limit_mode_i)
             && cmd_on_i[i] && $past(cmd_on_i[i]) && !$past(gate_en_o[i])
             && !$past(ot_i[i], 3))
            |-> !gate_en_o[i]); // R4

        AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && $past(ot_i[i], 2))
            |-> !gate_en_o[i]); // R7

        AST_OPEN_LOAD_OFF: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && !cmd_on_i[i])
            |-> (drain_stat_o[i] == !$past(ol_i[i], 2))); // R8

        AST_ON_READS_LOW: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && cmd_on_i[i] && gate_en_o[i]
             && !$past(oc_i[i], 2))
            |-> !drain_stat_o[i]); // R9
    end
endmodule

bind fp_protect fp_protect_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .uv_i           (uv_i),
    .limit_mode_i   (limit_mode_i),
    .write_strobe_i (write_strobe_i),
    .cmd_on_i       (cmd_on_i),
    .oc_i           (oc_i),
    .ot_i           (ot_i),
    .ol_i           (ol_i),
    .gate_en_o      (gate_en_o),
    .drain_stat_o   (drain_stat_o)
);

// File: tb/test_fp_protect.sv
module test_fp_protect;
    localparam int NUM_CH  = 8;
    localparam int NUM_VEC = 11;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] oc;
        logic [7:0] ot;
        logic [7:0] ol;
        logic       mode;
        logic       strobe;
        logic [7:0] exp_gate;
        logic [7:0] exp_drain;
        logic [3:0] req;
    } vec_t;

    // fields: cmd, oc, ot, ol, mode, strobe, gate, drain, requirement
    localparam vec_t VEC [NUM_VEC] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'hFF, 4'd1},  // R1 idle
        '{8'hA5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'hA5, 8'h5A, 4'd9},  // R9 encoding
        '{8'hA5, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 8'hA4, 8'h5B, 4'd3},  // R3 R6 ch0 trips
        '{8'hA5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'hA4, 8'h5B, 4'd4},  // R4 latch holds
        '{8'hA5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'hA5, 8'h5A, 4'd4},  // R4 strobe release
        '{8'hA5, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 8'hA5, 8'hDA, 4'd5},  // R5 limit mode
        '{8'hA5, 8'h80, 8'h20, 8'h00, 1'b1, 1'b0, 8'h85, 8'hFA, 4'd7},  // R7 thermal
        '{8'hA5, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'hA5, 8'h5A, 4'd7},  // R7 auto return
        '{8'hA5, 8'h00, 8'h00, 8'h03, 1'b1, 1'b0, 8'hA5, 8'h58, 4'd8},  // R8 open load
        '{8'h0F, 8'hF0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h0F, 8'hF0, 4'd3},  // R3 off chans
        '{8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 8'h00, 4'd4}   // R4 R6 all on
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              uv_i = 1'b0;
    logic              limit_mode_i = 1'b0;
    logic              write_strobe_i = 1'b0;
    logic [NUM_CH-1:0] cmd_on_i = '0;
    logic [NUM_CH-1:0] oc_i = '0;
    logic [NUM_CH-1:0] ot_i = '0;
    logic [NUM_CH-1:0] ol_i = '0;
    logic [NUM_CH-1:0] gate_en_o;
    logic [NUM_CH-1:0] drain_stat_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    fp_protect #(.NUM_CH(NUM_CH)) i_fp_protect (
        .clk            (clk),
        .rst            (rst),
        .uv_i           (uv_i),
        .limit_mode_i   (limit_mode_i),
        .write_strobe_i (write_strobe_i),
        .cmd_on_i       (cmd_on_i),
        .oc_i           (oc_i),
        .ot_i           (ot_i),
        .ol_i           (ol_i),
        .gate_en_o      (gate_en_o),
        .drain_stat_o   (drain_stat_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(4);
        rst = 1'b0;
        edges(1);
        // R2 reset state
        chk(gate_en_o, 8'h00, 2, "reset gate");
        chk(drain_stat_o, 8'hFF, 2, "reset drain");

        for (int v = 0; v < NUM_VEC; v++) begin
            cmd_on_i     = VEC[v].cmd;
            oc_i         = VEC[v].oc;
            ot_i         = VEC[v].ot;
            ol_i         = VEC[v].ol;
            limit_mode_i = VEC[v].mode;
            edges(2);
            if (VEC[v].strobe) begin
                write_strobe_i = 1'b1;
                edges(1);
                write_strobe_i = 1'b0;
            end else begin
                edges(1);
            end
            chk(gate_en_o, VEC[v].exp_gate, int'(VEC[v].req), "vector gate");
            chk(drain_stat_o, VEC[v].exp_drain, int'(VEC[v].req), "vector drain");
        end

        // R2 undervoltage clears a latch
        oc_i = 8'h01;
        edges(3);
        chk(gate_en_o, 8'hFE, 3, "trip before undervoltage");
        oc_i = 8'h00;
        edges(3);
        chk(gate_en_o, 8'hFE, 4, "latched before undervoltage");
        uv_i = 1'b1;
        edges(1);
        uv_i = 1'b0;
        chk(gate_en_o, 8'hFF, 2, "undervoltage release");

        // R2 reset clears a latch
        oc_i = 8'h02;
        edges(3);
        oc_i = 8'h00;
        edges(3);
        chk(gate_en_o, 8'hFD, 4, "latched before reset");
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        edges(1);
        chk(gate_en_o, 8'hFF, 2, "reset release gate");
        chk(drain_stat_o, 8'h00, 2, "reset release drain");

        // R10 two-flop latency, R7 recovery
        ot_i = 8'h01;
        edges(1);
        chk(gate_en_o, 8'hFF, 10, "one edge after flag");
        edges(1);
        chk(gate_en_o, 8'hFE, 10, "two edges after flag");
        chk(drain_stat_o, 8'h01, 9, "shut-down channel reads high");
        ot_i = 8'h00;
        edges(3);
        chk(gate_en_o, 8'hFF, 7, "thermal recovery");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule